// File: doc/BRIEF.md
# PLL Scan-Chain Reconfiguration Sequencer

This block reprograms a PLL's divide counters and loop-filter settings through the PLL's serial scan chain. The user presents a 144-bit configuration word and pulses a start request. The sequencer latches the word and raises the scan-clock enable one cycle before any data is used. It then streams the word out most significant bit first, drops the enable, and fires a one-cycle update strobe. It then waits for the PLL's returned done flag to fall.

The sequencer compares the accepted word against the previously accepted word. If any bit under the change mask differs, it drives a fixed-width PLL reset pulse before it reports completion. If the done flag never falls, a timeout ends the sequence with an error pulse instead. All logic runs on the scan clock. The returned done flag passes through a two-flop synchronizer before its falling edge is detected.

The state machine has these states:
- IDLE
- LEAD: enable raised, no data used.
- SHIFT: one chain bit per cycle.
- UPDATE: strobe.
- WAIT: waiting for the done flag to fall, with a timeout.
- PRST: PLL reset pulse.
- DONE: completion pulse.
- TOUT: timeout pulse.

The transitions are:
- IDLE→LEAD on an accepted start.
- LEAD→SHIFT after one cycle.
- SHIFT→UPDATE after the last bit.
- UPDATE→WAIT after one cycle.
- WAIT→PRST on a done fall when the word changed.
- WAIT→DONE on a done fall when it did not change.
- WAIT→TOUT when the timeout expires.
- PRST→DONE after the reset width.
- DONE→IDLE and TOUT→IDLE after one cycle.

Top module: `pll_scan_reconfig`

## Requirements
- R1: Each accepted request holds `scan_en` high for exactly CHAIN_LEN+1 = 145 consecutive clock cycles, and the first of these is a lead cycle in which no chain bit is used.
- R2: Sampled at the 2nd through 145th rising edges at which `scan_en` is high, `scan_data` carries `cfg_word` bit 143 first and bit 0 last.
- R3: `scan_en` rises exactly once per request and stays low from the end of shifting until the next accepted request.
- R4: `cfg_update` is high for exactly one cycle per request, only after shifting ends, and never while `scan_en` is high.
- R5: Neither `pll_reset` nor `complete` asserts before the returned `done_in` flag has fallen after the update strobe.
- R6: `pll_reset` is high for exactly RST_CYCLES (default 2) cycles when the accepted word differs, under CHANGE_MASK (default all ones), from the previously accepted word. It stays low otherwise. The stored word is all zeros after reset and is replaced at every accepted request.
- R7: `complete` pulses for one cycle after the reset pulse, or directly after the done fall if no reset is needed. `busy` is high from the cycle after an accepted start through the `complete` cycle.
- R8: A `start` that arrives while `busy` is high is ignored. Its word is neither shifted nor stored for comparison.
- R9: If `done_in` does not fall within TIMEOUT_CYCLES after the update strobe, `timeout_err` pulses for one cycle and no reset or `complete` follows. The word still counts as the stored word.
- R10: After reset, `busy`, `scan_en`, `scan_data`, `cfg_update`, `pll_reset`, `complete` and `timeout_err` are all low.
- R11: The sequence can be repeated any number of times. Each new request behaves the same as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a reconfiguration (taken only when idle) |
| cfg_word | input | 144 | Configuration word to shift into the chain |
| done_in | input | 1 | Done/busy flag returned from the PLL (asynchronous) |
| scan_en | output | 1 | Scan-clock enable toward the PLL |
| scan_data | output | 1 | Serial chain data, MSB first |
| cfg_update | output | 1 | One-cycle configuration-update strobe |
| pll_reset | output | 1 | PLL reset pulse after a changed configuration |
| busy | output | 1 | Sequence in progress |
| complete | output | 1 | One-cycle pulse when the sequence succeeds |
| timeout_err | output | 1 | One-cycle pulse when the done flag never fell |

## Verification
A corrupted state register or bit counter shows up at the ports within a single request. The enable run has the wrong length, or a bit of the 144 captured at the PLL side comes out misplaced. A missing reset pulse is caught at the end of the same request, and so is an extra one. A stale comparison register is caught one request later, because repeating a word must then produce no reset. A premature exit from the wait state appears as a reset or completion before the done flag falls, a few cycles after the update strobe.

// File: rtl/pllrc_pkg.sv
package pllrc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_UPDATE,
        ST_WAIT,
        ST_PRST,
        ST_DONE,
        ST_TOUT
    } state_t;
endpackage

// File: rtl/pllrc_done_sync.sv
module pllrc_done_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic done_async,
    output logic done_fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= done_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign done_fall = prev_q & ~sync_q;
endmodule

// File: rtl/pllrc_shifter.sv
module pllrc_shifter #(
    parameter int CHAIN_LEN = 144
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [CHAIN_LEN-1:0] word,
    input  logic                 shift,
    output logic                 sdo,
    output logic                 last
);
    localparam int CW = $clog2(CHAIN_LEN + 1);

    logic [CHAIN_LEN-1:0] sreg_q;
    logic [CW-1:0]        cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            sreg_q <= word;
            cnt_q  <= '0;
        end else if (shift) begin
            sreg_q <= {sreg_q[CHAIN_LEN-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sdo  = sreg_q[CHAIN_LEN-1];
    assign last = (cnt_q == CW'(CHAIN_LEN - 1));
endmodule

// File: rtl/pllrc_change_det.sv
module pllrc_change_det #(
    parameter int                 CHAIN_LEN   = 144,
    parameter logic [CHAIN_LEN-1:0] CHANGE_MASK = {CHAIN_LEN{1'b1}}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [CHAIN_LEN-1:0] word,
    output logic                 changed
);
    logic [CHAIN_LEN-1:0] shadow_q;
    logic                 chg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            chg_q    <= 1'b0;
        end else if (load) begin
            shadow_q <= word;
            chg_q    <= |((word ^ shadow_q) & CHANGE_MASK);
        end
    end

    assign changed = chg_q;
endmodule

// File: rtl/pll_scan_reconfig.sv
module pll_scan_reconfig
    import pllrc_pkg::*;
#(
    parameter int                   CHAIN_LEN      = 144,
    parameter int                   RST_CYCLES     = 2,
    parameter int                   TIMEOUT_CYCLES = 4096,
    parameter logic [CHAIN_LEN-1:0] CHANGE_MASK    = {CHAIN_LEN{1'b1}}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CHAIN_LEN-1:0] cfg_word,
    input  logic                 done_in,
    output logic                 scan_en,
    output logic                 scan_data,
    output logic                 cfg_update,
    output logic                 pll_reset,
    output logic                 busy,
    output logic                 complete,
    output logic                 timeout_err
);
    localparam int LIMIT = (TIMEOUT_CYCLES > RST_CYCLES) ? TIMEOUT_CYCLES : RST_CYCLES;
    localparam int TW    = $clog2(LIMIT + 1);

    state_t        state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic          load, shift, sdo, last, changed, done_fall;

    assign load  = (state_q == ST_IDLE) && start;
    assign shift = (state_q == ST_SHIFT);

    pllrc_done_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_async (done_in),
        .done_fall  (done_fall)
    );

    pllrc_shifter #(.CHAIN_LEN(CHAIN_LEN)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .word  (cfg_word),
        .shift (shift),
        .sdo   (sdo),
        .last  (last)
    );

    pllrc_change_det #(.CHAIN_LEN(CHAIN_LEN), .CHANGE_MASK(CHANGE_MASK)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .word    (cfg_word),
        .changed (changed)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LEAD;
            ST_LEAD:   state_d = ST_SHIFT;
            ST_SHIFT:  if (last) state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (done_fall)
                    state_d = changed ? ST_PRST : ST_DONE;
                else if (tmr_q == TW'(TIMEOUT_CYCLES - 1))
                    state_d = ST_TOUT;
            end
            ST_PRST:   if (tmr_q == TW'(RST_CYCLES - 1)) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_TOUT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // dwell timer, restarts on each state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  tmr_q <= '0;
        else if (state_d != state_q) tmr_q <= '0;
        else                         tmr_q <= tmr_q + 1'b1;
    end

    // outputs
    always_comb begin
        scan_en     = 1'b0;
        scan_data   = 1'b0;
        cfg_update  = 1'b0;
        pll_reset   = 1'b0;
        complete    = 1'b0;
        timeout_err = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_LEAD:   scan_en = 1'b1;
            ST_SHIFT: begin
                scan_en   = 1'b1;
                scan_data = sdo;
            end
            ST_UPDATE: cfg_update = 1'b1;
            ST_WAIT:   ;
            ST_PRST:   pll_reset = 1'b1;
            ST_DONE:   complete = 1'b1;
            ST_TOUT:   timeout_err = 1'b1;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pllrc_checker.sv
module pllrc_checker #(
    parameter int CHAIN_LEN = 144
) (
    input logic clk,
    input logic rst_n,
    input logic scan_en,
    input logic cfg_update,
    input logic pll_reset,
    input logic busy,
    input logic complete,
    input logic timeout_err
);
    localparam int RW = $clog2(CHAIN_LEN + 2) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (scan_en) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    p_run_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (run_q == RW'(CHAIN_LEN + 1)));

    p_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en) |=> scan_en);

    p_upd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !cfg_update);

    p_upd_no_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |-> !scan_en);

    p_rst_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_reset |-> busy);

    p_cmp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (!complete && !busy));

    p_tout_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (!complete && !pll_reset));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scan_en && !cfg_update && !pll_reset));
endmodule

bind pll_scan_reconfig pllrc_checker #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .cfg_update  (cfg_update),
    .pll_reset   (pll_reset),
    .busy        (busy),
    .complete    (complete),
    .timeout_err (timeout_err)
);

// File: tb/tb_pll_scan_reconfig.sv
module tb_pll_scan_reconfig;
    localparam int N   = 144;
    localparam int RST = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] cfg_word = '0;
    logic         done_in = 1'b0;
    logic         scan_en, scan_data, cfg_update, pll_reset, busy, complete, timeout_err;

    int checks = 0;
    int errors = 0;
    logic pll_dead = 1'b0;

    always #10 clk = ~clk;

    pll_scan_reconfig #(.CHAIN_LEN(N), .RST_CYCLES(RST), .TIMEOUT_CYCLES(64)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .done_in(done_in),
        .scan_en(scan_en), .scan_data(scan_data), .cfg_update(cfg_update),
        .pll_reset(pll_reset), .busy(busy), .complete(complete), .timeout_err(timeout_err)
    );

    // PLL-side monitor and model, sampled mid-cycle
    logic [N-1:0] cap = '0;
    int en_run = 0, last_run = 0, en_rise = 0, upd_cnt = 0, upd_bad = 0;
    int rst_cnt = 0, cmp_cnt = 0, tout_cnt = 0, bad_order = 0;
    int pend = 0, hold = 0;
    logic armed = 1'b0;

    always @(negedge clk) begin
        if (scan_en) begin
            if (en_run == 0) en_rise++;
            en_run++;
            if (en_run >= 2) cap = {cap[N-2:0], scan_data};
        end else if (en_run != 0) begin
            last_run = en_run;
            en_run = 0;
        end
        if (cfg_update) begin
            upd_cnt++;
            if (scan_en) upd_bad++;
            armed = 1'b1;
            if (!pll_dead) pend = 3;
        end
        if (pll_reset) begin rst_cnt++; if (armed) bad_order++; end
        if (complete)  begin cmp_cnt++; if (armed) bad_order++; end
        if (timeout_err) begin tout_cnt++; armed = 1'b0; end
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin done_in = 1'b1; hold = 5; end
        end else if (hold > 0) begin
            hold--;
            if (hold == 0) begin done_in = 1'b0; armed = 1'b0; end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [N-1:0] w, input logic exp_rst, input logic poke, input logic dead);
        int s_rise, s_upd, s_ubad, s_rst, s_cmp, s_tout, s_bad, guard;
        pll_dead = dead;
        @(negedge clk);
        s_rise = en_rise; s_upd = upd_cnt; s_ubad = upd_bad; s_rst = rst_cnt;
        s_cmp = cmp_cnt; s_tout = tout_cnt; s_bad = bad_order;
        start = 1'b1; cfg_word = w;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", N'(busy), N'(1));
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1; cfg_word = ~w;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 2000) begin @(negedge clk); guard++; end
        chk(guard < 2000, "R11 sequence ends", N'(guard), N'(0));
        chk(en_rise - s_rise == 1, "R3 one enable run", N'(en_rise - s_rise), N'(1));
        chk(last_run == N + 1, "R1 enable length", N'(last_run), N'(N + 1));
        chk(cap == (poke ? w : w), "R2 shifted bits MSB first (R8 poke ignored)", cap, w);
        chk(upd_cnt - s_upd == 1, "R4 one update", N'(upd_cnt - s_upd), N'(1));
        chk(upd_bad == s_ubad, "R4 update without enable", N'(upd_bad - s_ubad), N'(0));
        chk(bad_order == s_bad, "R5 waits for done fall", N'(bad_order - s_bad), N'(0));
        chk(rst_cnt - s_rst == (exp_rst ? RST : 0), "R6 reset pulse width",
            N'(rst_cnt - s_rst), N'(exp_rst ? RST : 0));
        chk(cmp_cnt - s_cmp == (dead ? 0 : 1), "R7 complete pulse",
            N'(cmp_cnt - s_cmp), N'(dead ? 0 : 1));
        chk(tout_cnt - s_tout == (dead ? 1 : 0), "R9 timeout pulse",
            N'(tout_cnt - s_tout), N'(dead ? 1 : 0));
        chk(!scan_en, "R3 enable low after sequence", N'(scan_en), N'(0));
        repeat (12) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] w;
        w = {36{4'hA}};
        repeat (3) @(negedge clk);
        chk(!busy, "R10 busy", N'(busy), N'(0));
        chk(!scan_en && !scan_data, "R10 scan", N'({scan_en, scan_data}), N'(0));
        chk(!cfg_update && !pll_reset, "R10 strobes", N'({cfg_update, pll_reset}), N'(0));
        chk(!complete && !timeout_err, "R10 status", N'({complete, timeout_err}), N'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !scan_en, "R10 after release", N'({busy, scan_en}), N'(0));

        run(w, 1'b1, 1'b0, 1'b0);            // R6 first word differs from zero
        run(w, 1'b0, 1'b0, 1'b0);            // R6 R11 repeat, no reset
        foreach (w[p]) begin
            if (p == 0 || p == 1 || p == 70 || p == 142 || p == 143) begin
                w[p] = ~w[p];
                run(w, 1'b1, 1'b0, 1'b0);    // R6 single bit change
                run(w, 1'b0, 1'b0, 1'b0);
            end
        end
        run({N{1'b1}}, 1'b1, 1'b0, 1'b0);
        run('0, 1'b1, 1'b0, 1'b0);
        run('0, 1'b0, 1'b0, 1'b0);
        w = {18{8'h3C}};
        run(w, 1'b1, 1'b1, 1'b0);            // R8 start while busy
        run(w, 1'b0, 1'b0, 1'b0);            // R8 ignored word not stored
        w = {9{16'h1234}};
        run(w, 1'b0, 1'b0, 1'b1);            // R9 timeout, no reset
        run(w, 1'b0, 1'b0, 1'b0);            // R9 word stored anyway

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule